// File: doc/BRIEF.md
# Instruction Repeat Controller

This block sequences the repetition of a single instruction. A repeat command loads an iteration counter. The value comes either from a 16-bit data-memory operand or from an 8-bit immediate, which is zero-extended. After the load, the block holds the next instruction in the fetch stage. The execution stage reports each completed pass with a done strobe, and the instruction stays held until the counter is used up.

A loaded count of N runs the instruction N+1 times. The counter goes down by one for each completed pass. The loop ends with the pass that starts while the counter reads zero. Because the repeated instruction is pipelined, a new pass may complete in every cycle.

While a repeat is in progress, the block masks every interrupt request line, including the non-maskable one. Only reset is still honoured. Requests that arrive while the mask is set are stored. They are presented for one cycle when the mask drops, merged with the live requests of that cycle.

Top module: `rpt_ctrl`

## Requirements
- R1: With `src_imm_i`=1, a load takes `imm_data_i` zero-extended as the count N, and the instruction then runs exactly N+1 times.
- R2: With `src_imm_i`=0, a load takes all 16 bits of `mem_data_i` as the count N, and the instruction then runs exactly N+1 times.
- R3: Each `iter_done_i` pulse while active counts as one execution. `iter_done_i` while idle has no effect.
- R4: `rpt_active_o` rises in the cycle after an accepted load. It falls in the cycle after the final pass completes.
- R5: `hold_instr_o` is high while active, except in the cycle where the final pass's `iter_done_i` is high. It is low while idle.
- R6: A load that arrives while a loop is active is ignored. The running count is not changed.
- R7: `irq_o` is all zeros whenever `rpt_load_i` or `rpt_active_o` is high, for every bit including bit 0 (non-maskable).
- R8: Requests seen while masked are stored. In the first unmasked cycle, `irq_o` equals the stored set ORed with `irq_i`. After that cycle, `irq_o` follows `irq_i` alone.
- R9: Passes can complete in back-to-back cycles. With `iter_done_i` held high, a count of N keeps `rpt_active_o` high for exactly N+1 cycles.
- R10: Asserting `rst_ni` low clears the counter, the active flag and the stored requests. `irq_o` then passes `irq_i` straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rpt_load_i | input | 1 | Repeat command decoded |
| src_imm_i | input | 1 | 1: immediate operand, 0: data-memory operand |
| mem_data_i | input | 16 | Data-memory count operand |
| imm_data_i | input | 8 | Immediate count operand |
| iter_done_i | input | 1 | One pass of the repeated instruction completed |
| irq_i | input | 8 | Interrupt requests, bit 0 non-maskable |
| rpt_active_o | output | 1 | Repeat loop in progress |
| hold_instr_o | output | 1 | Keep the current instruction in place |
| irq_o | output | 8 | Interrupt requests after masking |

## Verification
The mask on `irq_o` and the `hold_instr_o` drop are combinational, so the bench checks them in the same cycle as the stimulus, shortly after it drives the inputs. Inputs change on the falling edge. The active flag and the end of the loop are registered, so they are checked one edge later, on the next falling edge. The stored requests appear in the first cycle whose mask is low and are gone in the cycle after it. The bench counts passes in its own model and compares that count with N+1 at the cycle where `rpt_active_o` falls.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic {
    SRC_MEM = 1'b0,
    SRC_IMM = 1'b1
  } rpt_src_e;
endpackage

// File: rtl/rpt_operand_sel.sv
module rpt_operand_sel
  import rpt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IMM_W = 8
) (
  input  logic [0:0]       src_i,
  input  logic [CNT_W-1:0] mem_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [CNT_W-1:0] val_o
);
  localparam int PAD_W = (CNT_W > IMM_W) ? CNT_W - IMM_W : 0;
  logic [CNT_W-1:0] imm_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_ext = {{PAD_W{1'b0}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    if (rpt_src_e'(src_i) == SRC_IMM) val_o = imm_ext;
    else                              val_o = mem_i;
  end
endmodule

// File: rtl/rpt_counter.sv
module rpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             done_i,
  output logic             active_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             start;
  logic             cnt_zero;

  assign start    = load_i & ~active_q;
  assign cnt_zero = (cnt_q == '0);
  assign last_o   = active_q & done_i & cnt_zero;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start) begin
      cnt_q    <= val_i;
      active_q <= 1'b1;
    end else if (active_q && done_i) begin
      if (cnt_zero) active_q <= 1'b0;
      else          cnt_q    <= cnt_q - 1'b1;
    end
  end

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !active_q) |=> (active_q && cnt_q == $past(val_i))); // R4
  AST_DEC_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && done_i && cnt_q != '0) |=> (active_q && cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_END_AFTER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && done_i && cnt_q == '0) |=> !active_q); // R4
  AST_IGNORE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && load_i && !done_i) |=> (active_q && $stable(cnt_q))); // R6
  AST_IDLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !load_i && done_i) |=> !active_q); // R3
endmodule

// File: rtl/rpt_irq_gate.sv
module rpt_irq_gate #(
  parameter int NIRQ = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mask_i,
  input  logic [NIRQ-1:0] irq_i,
  output logic [NIRQ-1:0] irq_o
);
  logic [NIRQ-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (mask_i) pend_q <= pend_q | irq_i;
    else             pend_q <= '0;
  end

  assign irq_o = mask_i ? '0 : (irq_i | pend_q);

  AST_PEND_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i && (irq_i != '0)) |=> (mask_i || ((irq_o & $past(irq_i)) == $past(irq_i)))); // R8
  AST_PEND_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_i) |=> (mask_i || irq_o == irq_i)); // R8
endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
  import rpt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IMM_W = 8,
  parameter int NIRQ  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rpt_load_i,
  input  logic             src_imm_i,
  input  logic [CNT_W-1:0] mem_data_i,
  input  logic [IMM_W-1:0] imm_data_i,
  input  logic             iter_done_i,
  input  logic [NIRQ-1:0]  irq_i,
  output logic             rpt_active_o,
  output logic             hold_instr_o,
  output logic [NIRQ-1:0]  irq_o
);
  logic [CNT_W-1:0] load_val;
  logic             active;
  logic             last_iter;
  logic             irq_mask;

  rpt_operand_sel #(.CNT_W(CNT_W), .IMM_W(IMM_W)) u_sel (
    .src_i (src_imm_i),
    .mem_i (mem_data_i),
    .imm_i (imm_data_i),
    .val_o (load_val)
  );

  rpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rpt_load_i),
    .val_i    (load_val),
    .done_i   (iter_done_i),
    .active_o (active),
    .last_o   (last_iter)
  );

  // mask from the decode cycle of the command onward
  assign irq_mask = active | rpt_load_i;

  rpt_irq_gate #(.NIRQ(NIRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mask_i (irq_mask),
    .irq_i  (irq_i),
    .irq_o  (irq_o)
  );

  assign rpt_active_o = active;
  assign hold_instr_o = active & ~last_iter;

  AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_active_o || rpt_load_i) |-> (irq_o == '0)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rpt_active_o |-> !hold_instr_o); // R5
  AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_active_o && !hold_instr_o) |=> !rpt_active_o); // R5
endmodule

// File: tb/sim_rpt_ctrl.sv
module sim_rpt_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rpt_load_i = 1'b0;
  logic        src_imm_i = 1'b0;
  logic [15:0] mem_data_i = '0;
  logic [7:0]  imm_data_i = '0;
  logic        iter_done_i = 1'b0;
  logic [7:0]  irq_i = '0;
  logic        rpt_active_o;
  logic        hold_instr_o;
  logic [7:0]  irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  rpt_ctrl u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint exp_execs(input bit imm, input logic [15:0] m, input logic [7:0] i);
    return imm ? longint'(i) + 1 : longint'(m) + 1;
  endfunction

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // full loop; mode 0: random done gaps, 1: done every cycle
  task automatic run_loop(input bit imm, input logic [15:0] m, input logic [7:0] i,
                          input int mode, input string req);
    longint n_exp = exp_execs(imm, m, i);
    longint done_cnt = 0;
    int act_cycles = 0;
    logic [7:0] pend = '0;
    @(negedge clk_i);
    rpt_load_i = 1; src_imm_i = imm; mem_data_i = m; imm_data_i = i;
    iter_done_i = 0; irq_i = 8'($urandom);
    pend |= irq_i;
    #1 chk(irq_o == 0, "R7", irq_o, 0);
    @(negedge clk_i);
    chk(rpt_active_o == 1, "R4", rpt_active_o, 1);
    while (rpt_active_o && act_cycles < 70000) begin
      bit d = (mode == 1) ? 1'b1 : 1'(($urandom % 3) != 0);
      rpt_load_i = 1'(($urandom % 4) == 0);
      src_imm_i = 1'($urandom); mem_data_i = 16'($urandom); imm_data_i = 8'($urandom);
      iter_done_i = d;
      irq_i = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      pend |= irq_i;
      #1;
      chk(irq_o == 0, "R7", irq_o, 0);
      chk(hold_instr_o == !(d && done_cnt == n_exp - 1), "R5", hold_instr_o,
          !(d && done_cnt == n_exp - 1));
      @(negedge clk_i);
      if (d) done_cnt++;
      act_cycles++;
    end
    chk(done_cnt == n_exp, req, done_cnt, n_exp);
    if (mode == 1) chk(act_cycles == n_exp, "R9", act_cycles, n_exp);
    rpt_load_i = 0; iter_done_i = 0; irq_i = 0;
    #1 chk(irq_o == pend, "R8", irq_o, pend);
    chk(hold_instr_o == 0, "R5", hold_instr_o, 0);
    @(negedge clk_i);
    irq_i = 8'h21;
    #1 chk(irq_o == 8'h21, "R8", irq_o, 8'h21);
    irq_i = 0;
  endtask

  initial begin
    #1;
    chk(rpt_active_o == 0 && hold_instr_o == 0, "R10", rpt_active_o, 0);
    irq_i = 8'h5A;
    #1 chk(irq_o == 8'h5A, "R10", irq_o, 8'h5A);
    irq_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    void'($urandom(32'd1234));

    // R3: done while idle does nothing
    @(negedge clk_i);
    iter_done_i = 1;
    @(negedge clk_i);
    chk(rpt_active_o == 0, "R3", rpt_active_o, 0);
    chk(hold_instr_o == 0, "R5", hold_instr_o, 0);
    iter_done_i = 0;

    // directed corners
    run_loop(1, 16'hFFFF, 8'd0,   0, "R1");
    run_loop(1, 16'h0000, 8'd255, 1, "R1");
    run_loop(0, 16'h0000, 8'd9,   1, "R2");
    run_loop(0, 16'h0103, 8'd0,   0, "R2");
    run_loop(0, 16'h1234, 8'd7,   1, "R2");

    // constrained random loops
    for (int k = 0; k < 24; k++) begin
      bit imm = 1'($urandom);
      run_loop(imm, 16'($urandom % 300), 8'($urandom), int'($urandom % 2), imm ? "R1" : "R2");
    end

    // R6: reload during loop ignored, directed
    @(negedge clk_i);
    rpt_load_i = 1; src_imm_i = 1; imm_data_i = 8'd2;
    @(negedge clk_i);
    rpt_load_i = 1; imm_data_i = 8'd50; iter_done_i = 1;
    repeat (3) @(negedge clk_i);
    rpt_load_i = 0; iter_done_i = 0;
    chk(rpt_active_o == 0, "R6", rpt_active_o, 0);

    // R10: reset mid-loop drops active and stored requests
    @(negedge clk_i);
    rpt_load_i = 1; src_imm_i = 1; imm_data_i = 8'd40; irq_i = 8'hFF;
    @(negedge clk_i);
    rpt_load_i = 0; irq_i = 8'h81;
    @(negedge clk_i);
    irq_i = 0;
    rst_ni = 0;
    #1;
    chk(rpt_active_o == 0, "R10", rpt_active_o, 0);
    chk(irq_o == 0, "R10", irq_o, 0);
    @(negedge clk_i);
    rst_ni = 1;
    irq_i = 8'h01;
    #1 chk(irq_o == 8'h01, "R10", irq_o, 8'h01);
    irq_i = 0;
    @(negedge clk_i);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule